// File: doc/BRIEF.md
# AXI4 Write Beat-Count Checker

This block watches the write-address and write-data channels of an AXI4 link without driving any of their signals. Every accepted write-address transfer contributes its burst length to an in-order list of pending bursts. Every accepted write-data beat is counted against the oldest pending length. The block then decides whether the last-beat marker came on the right beat.

Write data may be accepted before its address. In that case the checker counts the beats provisionally and judges them when the matching address handshake arrives, which can be in the same cycle as a beat. It tracks a lead of at most one burst. Mismatches set sticky bits in an error vector, which a synchronous clear pulse resets. A counter records every burst that ended correctly.

The block is meant to sit beside a bus port in simulation or on silicon, as a passive protocol guard.

Top module: `wr_beat_checker`

## Requirements
- R1: After reset, `errVec` is all zero and `burstCount` is zero.
- R2: A burst with pending length L ends correctly when `wLast` is high on accepted beat L+1 and was low on every earlier beat. This includes L=0 with `wLast` on the single beat. A correct end adds one to `burstCount` and sets no error bit.
- R3: If `wLast` is high on an accepted beat before beat L+1, the checker sets `errVec[0]` (early last). The burst is then treated as finished.
- R4: If accepted beat L+1 arrives with `wLast` low, the checker sets `errVec[1]` (missing last). The burst is then treated as finished.
- R5: Beats accepted while no length is pending are counted provisionally. They are judged against the next accepted length by the R2, R3 and R4 rules, including when the address handshake and a beat fall in the same cycle.
- R6: The checker sets `errVec[2]` (overrun) in two cases. The first is when provisionally counted beats exceed L+1 for the length L that later arrives. The second is when a beat is accepted after a provisional burst has already ended with `wLast` and no length is pending yet.
- R7: An address handshake that finds DEPTH lengths pending, with none retiring in that cycle, sets `errVec[3]` (queue overflow). That length is discarded.
- R8: Lengths are consumed in the order of their address handshakes. The beat after a burst ends belongs to the next pending length.
- R9: Error bits stay set until `clrErr` is high at a clock edge. An error detected in that same cycle is still recorded.
- R10: A transfer counts only when its valid and ready are both high. Valid without ready changes neither the beat count nor the pending lengths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clrErr | input | 1 | Synchronous clear of the sticky error bits |
| awValid | input | 1 | Observed write-address valid |
| awReady | input | 1 | Observed write-address ready |
| awLen | input | 8 | Observed burst length field (beats minus one) |
| wValid | input | 1 | Observed write-data valid |
| wReady | input | 1 | Observed write-data ready |
| wLast | input | 1 | Observed last-beat marker |
| errVec | output | 4 | Sticky errors: bit 0 early last, bit 1 missing last, bit 2 overrun, bit 3 queue overflow |
| burstCount | output | CNT_W | Number of correctly ended bursts, wrapping |

## Verification
The delicate collision is an address handshake in the same cycle as a data beat while no length is pending. The checker must decide in one step whether that beat finishes, breaks or extends the provisional burst, and whether a beat arriving beside a resolving address starts a fresh provisional burst. Directed cases cause these collisions for a one-beat burst, a provisional burst already closed, and beats that exceed the arriving length. Random traffic with independent valid and ready on both channels causes many more. Each cycle's error vector and burst count are compared with a bench model that applies the requirement rules in order.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  localparam int LEN_W  = 8;
  localparam int BEAT_W = LEN_W + 1;
  localparam int ERR_W  = 4;

  localparam int ERR_EARLY    = 0;
  localparam int ERR_MISSING  = 1;
  localparam int ERR_OVERRUN  = 2;
  localparam int ERR_OVERFLOW = 3;

  typedef struct packed {
    logic              push;
    logic              pop;
    logic [BEAT_W-1:0] beatNext;
    logic              provNext;
    logic              burstInc;
    logic [ERR_W-1:0]  errSet;
  } wbcStrobes_t;
endpackage

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
  import wbc_pkg::*;
(
  input  logic              awFire,
  input  logic              wFire,
  input  logic              wLast,
  input  logic [LEN_W-1:0]  awLen,
  input  logic              qEmpty,
  input  logic              qFull,
  input  logic [LEN_W-1:0]  qHead,
  input  logic [BEAT_W-1:0] beatCnt,
  input  logic              provClosed,
  output wbcStrobes_t       st
);
  logic [BEAT_W-1:0] lenP1;
  logic [BEAT_W-1:0] headP1;
  logic [BEAT_W-1:0] beatInc;

  assign lenP1   = BEAT_W'(awLen) + BEAT_W'(1);
  assign headP1  = BEAT_W'(qHead) + BEAT_W'(1);
  assign beatInc = beatCnt + BEAT_W'(wFire);

  always_comb begin
    st          = '0;
    st.beatNext = beatCnt;
    st.provNext = provClosed;
    if (qEmpty) begin
      if (!provClosed) begin
        if (awFire) begin
          if (wFire && wLast) begin
            if (beatInc == lenP1)     st.burstInc = 1'b1;
            else if (beatInc < lenP1) st.errSet[ERR_EARLY] = 1'b1;
            else                      st.errSet[ERR_OVERRUN] = 1'b1;
            st.beatNext = '0;
          end else if (beatInc > lenP1) begin
            st.errSet[ERR_OVERRUN] = 1'b1;
            st.beatNext = '0;
          end else if (beatInc == lenP1) begin
            st.errSet[ERR_MISSING] = 1'b1;
            st.beatNext = '0;
          end else begin
            st.push     = 1'b1;
            st.beatNext = beatInc;
          end
        end else begin
          st.beatNext = beatInc;
          st.provNext = wFire && wLast;
        end
      end else begin
        if (awFire) begin
          if (beatCnt == lenP1)     st.burstInc = 1'b1;
          else if (beatCnt < lenP1) st.errSet[ERR_EARLY] = 1'b1;
          else                      st.errSet[ERR_OVERRUN] = 1'b1;
          st.beatNext = BEAT_W'(wFire);
          st.provNext = wFire && wLast;
        end else if (wFire) begin
          st.errSet[ERR_OVERRUN] = 1'b1;
        end
      end
    end else begin
      if (wFire) begin
        if (wLast) begin
          if (beatInc == headP1) st.burstInc = 1'b1;
          else                   st.errSet[ERR_EARLY] = 1'b1;
          st.pop      = 1'b1;
          st.beatNext = '0;
        end else if (beatInc == headP1) begin
          st.errSet[ERR_MISSING] = 1'b1;
          st.pop      = 1'b1;
          st.beatNext = '0;
        end else begin
          st.beatNext = beatInc;
        end
      end
      if (awFire) begin
        if (!qFull || st.pop) st.push = 1'b1;
        else                  st.errSet[ERR_OVERFLOW] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wbc_datapath.sv
module wbc_datapath
  import wbc_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clrErr,
  input  logic [LEN_W-1:0]  awLen,
  input  wbcStrobes_t       st,
  output logic              qEmpty,
  output logic              qFull,
  output logic [LEN_W-1:0]  qHead,
  output logic [BEAT_W-1:0] beatCnt,
  output logic              provClosed,
  output logic [ERR_W-1:0]  errVec,
  output logic [CNT_W-1:0]  burstCount
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [OCC_W-1:0] occ;
  logic [LEN_W-1:0] slotVal [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [LEN_W-1:0] slotQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  slotQ <= '0;
      else if (st.push && wrPtr == PTR_W'(g))     slotQ <= awLen;
    end
    assign slotVal[g] = slotQ;
  end

  function automatic logic [PTR_W-1:0] ptrAdv(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      occ   <= '0;
    end else begin
      if (st.push) wrPtr <= ptrAdv(wrPtr);
      if (st.pop)  rdPtr <= ptrAdv(rdPtr);
      if (st.push && !st.pop)      occ <= occ + OCC_W'(1);
      else if (st.pop && !st.push) occ <= occ - OCC_W'(1);
    end
  end

  assign qEmpty = (occ == '0);
  assign qFull  = (occ == OCC_W'(DEPTH));
  assign qHead  = slotVal[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beatCnt    <= '0;
      provClosed <= 1'b0;
      errVec     <= '0;
      burstCount <= '0;
    end else begin
      beatCnt    <= st.beatNext;
      provClosed <= st.provNext;
      errVec     <= (clrErr ? '0 : errVec) | st.errSet;
      if (st.burstInc) burstCount <= burstCount + CNT_W'(1);
    end
  end
endmodule

// File: rtl/wr_beat_checker.sv
module wr_beat_checker
  import wbc_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clrErr,
  input  logic              awValid,
  input  logic              awReady,
  input  logic [LEN_W-1:0]  awLen,
  input  logic              wValid,
  input  logic              wReady,
  input  logic              wLast,
  output logic [ERR_W-1:0]  errVec,
  output logic [CNT_W-1:0]  burstCount
);
  logic              awFire;
  logic              wFire;
  logic              qEmpty;
  logic              qFull;
  logic [LEN_W-1:0]  qHead;
  logic [BEAT_W-1:0] beatCnt;
  logic              provClosed;
  wbcStrobes_t       st;

  assign awFire = awValid && awReady;
  assign wFire  = wValid && wReady;

  wbc_ctrl i_ctrl (
    .awFire     (awFire),
    .wFire      (wFire),
    .wLast      (wLast),
    .awLen      (awLen),
    .qEmpty     (qEmpty),
    .qFull      (qFull),
    .qHead      (qHead),
    .beatCnt    (beatCnt),
    .provClosed (provClosed),
    .st         (st)
  );

  wbc_datapath #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .clrErr     (clrErr),
    .awLen      (awLen),
    .st         (st),
    .qEmpty     (qEmpty),
    .qFull      (qFull),
    .qHead      (qHead),
    .beatCnt    (beatCnt),
    .provClosed (provClosed),
    .errVec     (errVec),
    .burstCount (burstCount)
  );
endmodule

// File: rtl/wbc_sva.sv
module wbc_sva #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             clrErr,
  input logic             awValid,
  input logic             awReady,
  input logic             wValid,
  input logic             wReady,
  input logic             qEmpty,
  input logic             qFull,
  input logic             provClosed,
  input logic [3:0]       errVec,
  input logic [CNT_W-1:0] burstCount
);
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    !clrErr |=> ((errVec & $past(errVec)) == $past(errVec)));

  assert_idle_no_error_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!(awValid && awReady) && !(wValid && wReady)) |=> ((errVec & ~$past(errVec)) == 4'b0));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (CNT_W'(burstCount - $past(burstCount)) <= CNT_W'(1)));

  assert_count_needs_transfer_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!(awValid && awReady) && !(wValid && wReady)) |=> $stable(burstCount));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (awValid && awReady && !qFull && !errVec[3]) |=> !errVec[3]);

  assert_provisional_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    provClosed |-> qEmpty);
endmodule

bind wr_beat_checker wbc_sva #(.CNT_W(CNT_W)) i_wbc_sva (
  .clk        (clk),
  .rstN       (rstN),
  .clrErr     (clrErr),
  .awValid    (awValid),
  .awReady    (awReady),
  .wValid     (wValid),
  .wReady     (wReady),
  .qEmpty     (qEmpty),
  .qFull      (qFull),
  .provClosed (provClosed),
  .errVec     (errVec),
  .burstCount (burstCount)
);

// File: tb/test_wr_beat_checker.sv
module test_wr_beat_checker;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN, clrErr, awValid, awReady, wValid, wReady, wLast;
  logic [7:0] awLen;
  logic [3:0] errVec;
  logic [CNT_W-1:0] burstCount;

  int checks = 0;
  int errors = 0;

  // bench model state
  int  mq[$];
  int  mn = 0;
  bit  mc = 0;
  bit [3:0] mErr = 0;
  int  mBursts = 0;

  int  awPlan[$];
  bit  wPlan[$];

  wr_beat_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_wr_beat_checker (
    .clk(clk), .rstN(rstN), .clrErr(clrErr), .awValid(awValid), .awReady(awReady),
    .awLen(awLen), .wValid(wValid), .wReady(wReady), .wLast(wLast),
    .errVec(errVec), .burstCount(burstCount)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // judge a burst of n beats that ended with a last marker against length L
  function automatic bit [3:0] judgeClosed(int n, int L);
    bit [3:0] e = 0;
    if (n == L + 1) mBursts++;
    else if (n < L + 1) e[0] = 1;
    else e[2] = 1;
    return e;
  endfunction

  function automatic void modelStep(bit aw, int L, bit w, bit wl, bit clr);
    bit [3:0] e = 0;
    bit doPop = 0;
    if (mq.size() == 0) begin
      if (!mc) begin
        int n2 = mn + (w ? 1 : 0);
        bit c2 = w && wl;
        if (aw) begin
          if (c2) begin e = judgeClosed(n2, L); mn = 0; end
          else if (n2 > L + 1) begin e[2] = 1; mn = 0; end
          else if (n2 == L + 1) begin e[1] = 1; mn = 0; end
          else begin mq.push_back(L); mn = n2; end
        end else begin
          mn = n2; mc = c2;
        end
      end else begin
        if (aw) begin
          e = judgeClosed(mn, L);
          mn = w ? 1 : 0;
          mc = w && wl;
        end else if (w) e[2] = 1;
      end
    end else begin
      int head = mq[0];
      if (w) begin
        int n2 = mn + 1;
        if (wl) begin
          if (n2 == head + 1) mBursts++; else e[0] = 1;
          doPop = 1; mn = 0;
        end else if (n2 == head + 1) begin
          e[1] = 1; doPop = 1; mn = 0;
        end else mn = n2;
      end
      if (doPop) void'(mq.pop_front());
      if (aw) begin
        if (mq.size() + (doPop ? 1 : 0) >= DEPTH + (doPop ? 1 : 0) && !doPop) e[3] = 1;
        else mq.push_back(L);
      end
    end
    mErr = (clr ? 4'b0 : mErr) | e;
  endfunction

  task automatic compare(string tag);
    checks++;
    if (errVec !== mErr || burstCount !== CNT_W'(mBursts)) begin
      errors++;
      $display("FAIL %s: errVec=%b burstCount=%0d expected errVec=%b burstCount=%0d",
               tag, errVec, burstCount, mErr, mBursts);
    end
  endtask

  task automatic tick(bit av, bit ar, int len, bit wv, bit wr, bit wl, bit clr, string tag);
    awValid = av; awReady = ar; awLen = 8'(len);
    wValid = wv; wReady = wr; wLast = wl; clrErr = clr;
    modelStep(av && ar, len, wv && wr, wl, clr);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic aw(int len, string tag);  tick(1, 1, len, 0, 0, 0, 0, tag); endtask
  task automatic beat(bit wl, string tag); tick(0, 0, 0, 1, 1, wl, 0, tag); endtask
  task automatic clear(string tag);        tick(0, 0, 0, 0, 0, 0, 1, tag); endtask

  function automatic void planBurst();
    int L = $urandom_range(0, 5);
    int kind = $urandom_range(0, 9);
    int nb = L + 1;
    awPlan.push_back(L);
    if (kind == 0 && L > 0) nb = L;
    for (int i = 0; i < nb; i++) wPlan.push_back((i == nb - 1) && kind != 1);
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog (R8): run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    rstN = 0; clrErr = 0; awValid = 0; awReady = 0; awLen = 0;
    wValid = 0; wReady = 0; wLast = 0;
    repeat (3) @(negedge clk);
    compare("R1 reset state");
    rstN = 1;
    @(negedge clk);
    compare("R1 after release");

    // R2: length 2, three beats, last on the third
    aw(2, "R2 aw");
    beat(0, "R2 b0"); beat(0, "R2 b1"); beat(1, "R2 last");
    // R2/R5: single-beat burst with address and data in the same cycle
    tick(1, 1, 0, 1, 1, 1, 0, "R5 R2 same-cycle single beat");
    // R3: early last
    aw(3, "R3 aw"); beat(0, "R3 b0"); beat(1, "R3 early last");
    clear("R9 clear after R3");
    // R4: missing last, then R8 next burst proceeds
    aw(1, "R4 aw"); aw(0, "R8 second aw");
    beat(0, "R4 b0"); beat(0, "R4 missing last");
    beat(1, "R8 next burst owns beat");
    clear("R9 clear after R4");
    // R5: data leads address
    beat(0, "R5 lead b0"); beat(0, "R5 lead b1"); beat(1, "R5 lead last");
    aw(2, "R5 resolve good");
    // R5: leading, unclosed, then address extends burst
    beat(0, "R5 lead open"); aw(3, "R5 push length"); beat(0, "R5 b1");
    beat(0, "R5 b2"); beat(1, "R5 b3 last");
    // R6: provisional beats exceed arriving length
    beat(0, "R6 p0"); beat(0, "R6 p1"); beat(1, "R6 p2 last");
    aw(1, "R6 overrun on resolve");
    clear("R9 clear after R6a");
    // R6: beat after closed provisional burst with no address pending
    beat(1, "R6 closed lead"); beat(0, "R6 extra beat overrun");
    // address resolving closed lead while a new beat arrives (collision)
    tick(1, 1, 0, 1, 1, 1, 0, "R5 resolve with fresh lead");
    aw(0, "R5 resolve fresh lead");
    clear("R9 clear after R6b");
    // R7: queue overflow
    for (int i = 0; i < DEPTH + 1; i++) aw(0, "R7 fill");
    for (int i = 0; i < DEPTH; i++) beat(1, "R7 drain");
    // R9: clear and a new error in the same cycle
    aw(1, "R9 aw");
    tick(0, 0, 0, 1, 1, 1, 1, "R9 clear with new early last");
    clear("R9 plain clear");
    // R10: valid without ready ignored
    tick(1, 0, 5, 1, 0, 1, 0, "R10 stalled transfers");
    aw(0, "R10 aw"); beat(1, "R10 burst unaffected");

    // constrained random traffic
    for (int cyc = 0; cyc < 4000; cyc++) begin
      bit av, ar, wv, wr, wl, clr;
      int len;
      if (awPlan.size() < 2 || wPlan.size() < 4) planBurst();
      av  = awPlan.size() > 0 && ($urandom % 100) < 35;
      ar  = ($urandom % 100) < 75;
      wv  = wPlan.size() > 0 && ($urandom % 100) < 60;
      wr  = ($urandom % 100) < 80;
      len = av ? awPlan[0] : int'($urandom % 256);
      wl  = wv ? wPlan[0] : 1'($urandom);
      clr = ($urandom % 100) < 4;
      tick(av, ar, len, wv, wr, wl, clr, "R8 random traffic");
      if (av && ar) void'(awPlan.pop_front());
      if (wv && wr) void'(wPlan.pop_front());
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule